// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Reporting

This block receives asynchronous serial characters from a single input line. A one-cycle tick is supplied at sixteen times the bit rate. The block watches the synchronised line for a falling edge and checks that the start bit is still low at its centre. It then samples each following bit at its centre: 7, 8 or 9 data bits sent least significant bit first, an optional odd or even parity bit, and one or two stop bits. The finished character is copied from the shift register into a receive buffer that the processor reads.

When a character reaches the buffer, `rx_full` is set and `rx_irq` pulses for one cycle. The block keeps three error flags and a combined error flag:

- **Parity error**: the received parity bit does not match the selected setting.
- **Framing error**: a stop bit was sampled low.
- **Overrun**: the buffer was still unread when the bit before the last stop bit of the next character was sampled. An overrun leaves the buffer unchanged and raises no interrupt.

A one-cycle read strobe marks the buffer as read and clears the flags. Dropping the enable clears the flags and abandons any character in progress.

The baud-rate divider, the choice of input pin and the register bus are outside the block. All configuration inputs must stay constant while a character is being received.

Top module: `srx_receiver`

## Requirements
- R1: While `rx_en` is low, nothing is received and `rx_irq` stays low. With `rx_en` high, a falling edge on the line starts a start bit. The start bit is accepted only if the line is still low 8 ticks after the edge; otherwise the block returns to idle and no character is delivered.
- R2: Data bits are sampled one every 16 ticks after the start-bit centre, least significant bit first. `len_sel` selects the length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 gives 9 bits, and 2'b11 is treated as 8 bits. The character appears right-justified in `rx_data`, with the unused upper bits at zero.
- R3: When `par_en` is 1, one parity bit follows the data. `par_odd`=1 expects an odd total count of ones across the data and parity bits, and `par_odd`=0 expects an even count. A mismatch sets `par_err` when the character lands. When `par_en` is 0, `par_err` stays 0.
- R4: `two_stop`=0 expects one stop bit and `two_stop`=1 expects two. If any expected stop bit is sampled low, `frm_err` is set when the character lands.
- R5: When a character lands, `rx_full` becomes 1 and `rx_irq` is high for exactly one cycle, both in the same cycle.
- R6: If `rx_full` is 1 when the bit just before the last stop bit is sampled, `ovr_err` is set when the character completes. The buffer is then left unchanged and `rx_irq` is not raised, even if the buffer is read between that sample and completion.
- R7: `err_sum` is 1 exactly when at least one of `ovr_err`, `frm_err` or `par_err` is 1.
- R8: A `rd_strobe` pulse clears `rx_full` and all error flags. Taking `rx_en` low clears all error flags in the next cycle but keeps `rx_full` and `rx_data`.
- R9: If `rd_strobe` is high in the same cycle that a character lands, the landing wins: `rx_full` stays 1 with the new data and its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | One-cycle pulse at 16x bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_en | input | 1 | Receive enable |
| len_sel | input | 2 | Character length select |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| rd_strobe | input | 1 | Buffer read pulse |
| rx_data | output | 9 | Receive buffer contents |
| rx_full | output | 1 | Buffer holds an unread character |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing flag |
| par_err | output | 1 | Parity flag |
| err_sum | output | 1 | Any error flag set |
| rx_irq | output | 1 | One-cycle receive interrupt request |

## Verification
Two events can fall in the same cycle: a processor read of the buffer and the landing of a new character. To provoke this, the bench first reads the old character early in the next frame. It then holds `rd_strobe` high through the whole last stop bit and releases it only once `rx_irq` is seen. The result is judged correct only if `rx_full` stays 1 with the new character's data and no overrun is reported.

A second case places a read after the overrun judgement point but before completion. This must still report an overrun and raise no interrupt.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SRX_DW  = 9;
    localparam int SRX_OSR = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } srx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } srx_cfg_t;

    typedef struct packed {
        logic [SRX_DW-1:0] data;
        logic              frm_bad;
        logic              par_bad;
    } srx_char_t;

    function automatic int char_len(input logic [1:0] sel);
        case (sel)
            2'b00:   return 7;
            2'b10:   return 9;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= 1'b1;
                    else     pipe[i] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= 1'b1;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OSR    = SRX_OSR,
    parameter int DATA_W = SRX_DW
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic      rx_en,
    input  srx_cfg_t  cfg,
    output logic      judge,
    output logic      done,
    output srx_char_t result
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

    srx_state_e        state;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              frm_bad;
    logic              stop_idx;
    logic              prev;
    logic [IW-1:0]     last_idx;
    logic [DATA_W-1:0] data_aligned;
    int                nb;

    always_comb begin
        nb           = char_len(cfg.len_sel);
        last_idx     = IW'(nb - 1);
        data_aligned = shreg >> (DATA_W - nb);
    end

    assign result.data    = data_aligned;
    assign result.frm_bad = frm_bad;
    assign result.par_bad = cfg.par_en && ((^data_aligned ^ par_bit) != cfg.par_odd);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            frm_bad  <= 1'b0;
            stop_idx <= 1'b0;
            prev     <= 1'b1;
            judge    <= 1'b0;
            done     <= 1'b0;
        end else begin
            judge <= 1'b0;
            done  <= 1'b0;
            if (tick) prev <= line;
            if (!rx_en) begin
                state <= ST_IDLE;
            end else if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (prev && !line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF_M1) begin
                            cnt      <= '0;
                            bit_idx  <= '0;
                            frm_bad  <= 1'b0;
                            stop_idx <= 1'b0;
                            state    <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == FULL_M1) begin
                            cnt     <= '0;
                            shreg   <= {line, shreg[DATA_W-1:1]};
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == last_idx) begin
                                state <= cfg.par_en ? ST_PAR : ST_STOP;
                                judge <= !cfg.par_en && !cfg.two_stop;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == FULL_M1) begin
                            cnt     <= '0;
                            par_bit <= line;
                            state   <= ST_STOP;
                            judge   <= !cfg.two_stop;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == FULL_M1) begin
                            cnt <= '0;
                            if (!line) frm_bad <= 1'b1;
                            if (stop_idx == cfg.two_stop) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                stop_idx <= 1'b1;
                                judge    <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer
    import srx_pkg::*;
#(
    parameter int DATA_W = SRX_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rd,
    input  logic              judge,
    input  logic              done,
    input  srx_char_t         result,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ovr,
    output logic              frm,
    output logic              par,
    output logic              irq
);
    logic ovr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            data     <= '0;
            full     <= 1'b0;
            ovr      <= 1'b0;
            frm      <= 1'b0;
            par      <= 1'b0;
            irq      <= 1'b0;
            ovr_pend <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (done || !rx_en) ovr_pend <= 1'b0;
            else if (judge)     ovr_pend <= full;

            if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
                frm  <= 1'b0;
                par  <= 1'b0;
            end
            if (!rx_en) begin
                ovr <= 1'b0;
                frm <= 1'b0;
                par <= 1'b0;
            end else if (done) begin
                if (ovr_pend) begin
                    ovr <= 1'b1;
                end else begin
                    data <= result.data;
                    full <= 1'b1;
                    frm  <= result.frm_bad;
                    par  <= result.par_bad;
                    irq  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
    import srx_pkg::*;
#(
    parameter int OSR         = SRX_OSR,
    parameter int DATA_W      = SRX_DW,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_16x,
    input  logic              rx_in,
    input  logic              rx_en,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              par_err,
    output logic              err_sum,
    output logic              rx_irq
);
    logic      line_s;
    logic      judge;
    logic      done;
    srx_cfg_t  cfg;
    srx_char_t result;

    assign cfg = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (rx_in),
        .d_out (line_s)
    );

    srx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_16x),
        .line   (line_s),
        .rx_en  (rx_en),
        .cfg    (cfg),
        .judge  (judge),
        .done   (done),
        .result (result)
    );

    srx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .rx_en  (rx_en),
        .rd     (rd_strobe),
        .judge  (judge),
        .done   (done),
        .result (result),
        .data   (rx_data),
        .full   (rx_full),
        .ovr    (ovr_err),
        .frm    (frm_err),
        .par    (par_err),
        .irq    (rx_irq)
    );

    assign err_sum = ovr_err | frm_err | par_err;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              ovr_err,
    input logic              err_sum,
    input logic              rx_irq
);
    // R1: no delivery while disabled
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_irq);

    // R5: interrupt only with a full buffer
    p_irq_full_r5: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_full);

    // R5: interrupt is a single-cycle pulse
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    // R6: an overrun never raises the interrupt
    p_ovr_no_irq_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_err) |-> !rx_irq);

    // R6: buffer data only changes with a landing
    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        rx_full |=> (rx_irq || $stable(rx_data)));

    // R8: read empties the buffer unless a character lands
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> (rx_irq || !rx_full));

    // R8: disable clears the flags
    p_disable_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !err_sum);

    // R9: full buffer stays full until read
    p_hold_full_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_strobe) |=> rx_full);
endmodule

bind srx_receiver srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .rd_strobe (rd_strobe),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .ovr_err   (ovr_err),
    .err_sum   (err_sum),
    .rx_irq    (rx_irq)
);

// File: tb/srx_receiver_tb.sv
`timescale 1ns/1ps
module srx_receiver_tb;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_en = 1'b0;
    logic [1:0] len_sel = 2'b01;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, ovr_err, frm_err, par_err, err_sum, rx_irq;

    int checks = 0;
    int failures = 0;
    int irq_count = 0;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    srx_receiver u_dut (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .rx_in(rx_in), .rx_en(rx_en),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err),
        .frm_err(frm_err), .par_err(par_err), .err_sum(err_sum), .rx_irq(rx_irq)
    );

    always @(negedge clk) begin
        tcnt     <= (tcnt + 1) % 4;
        tick_16x <= (tcnt == 0);
        if (rx_irq) irq_count <= irq_count + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] s);
        return (s == 2'b00) ? 7 : (s == 2'b10) ? 9 : 8;
    endfunction

    function automatic logic [8:0] mask_data(input logic [8:0] d, input logic [1:0] s);
        return d & 9'((1 << nbits(s)) - 1);
    endfunction

    // rd_idx: bit index where a one-cycle read is pulsed (-1 none)
    // hold_last: hold read through the last stop bit until the interrupt
    task automatic send(input logic [8:0] d, input bit bad_par, input logic [1:0] bad_stop,
                        input int rd_idx, input bit hold_last);
        logic [12:0] bits;
        int          n;
        int          k;
        logic [8:0]  md;
        md = mask_data(d, len_sel);
        n = 0;
        bits = '0;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < nbits(len_sel); i++) begin bits[n] = md[i]; n++; end
        if (par_en) begin bits[n] = (^md) ^ par_odd ^ bad_par; n++; end
        bits[n] = !bad_stop[0]; n++;
        if (two_stop) begin bits[n] = !bad_stop[1]; n++; end
        for (int b = 0; b < n; b++) begin
            k = 0;
            @(negedge clk);
            rx_in = bits[b];
            if (hold_last && b == n - 1) rd_strobe = 1'b1;
            for (int c = 0; c < BITCLK; c++) begin
                @(negedge clk);
                if (b == rd_idx && c == 16) rd_strobe = 1'b1;
                else if (!hold_last || b != n - 1) rd_strobe = 1'b0;
                if (hold_last && b == n - 1 && rx_irq) rd_strobe = 1'b0;
            end
        end
        rd_strobe = 1'b0;
        rx_in = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    initial begin
        int         ic;
        logic [8:0] d, d2;
        logic [1:0] bs;
        bit         bp;
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rx_full && !err_sum && !rx_irq, "reset R5", {rx_full, err_sum, rx_irq}, 0);

        // R1: disabled, frame ignored
        ic = irq_count;
        send(9'h0A5, 0, 2'b00, -1, 0);
        chk(!rx_full && irq_count == ic, "disabled R1", rx_full, 0);

        rx_en = 1'b1;
        repeat (BITCLK) @(negedge clk);

        // R1: short low glitch rejected
        ic = irq_count;
        @(negedge clk); rx_in = 1'b0;
        repeat (8) @(negedge clk); rx_in = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        chk(!rx_full && irq_count == ic, "glitch R1", rx_full, 0);

        // R2: 8-bit character, upper bit zero
        send(9'h1C3, 0, 2'b00, -1, 0);
        chk(rx_full && rx_data == 9'h0C3, "len8 R2", rx_data, 9'h0C3);
        do_read();

        // R2/R5: random frames with mixed errors
        for (int t = 0; t < 36; t++) begin
            len_sel  = 2'($urandom_range(0, 3));
            par_en   = 1'($urandom);
            par_odd  = 1'($urandom);
            two_stop = 1'($urandom);
            d  = 9'($urandom);
            bp = ($urandom_range(0, 3) == 0);
            bs = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            if (!two_stop) bs[1] = 1'b0;
            ic = irq_count;
            send(d, bp, bs, -1, 0);
            chk(rx_full && irq_count == ic + 1, "land R5", irq_count - ic, 1);
            chk(rx_data == mask_data(d, len_sel), "data R2", rx_data, mask_data(d, len_sel));
            chk(par_err == (par_en && bp), "parity R3", par_err, par_en && bp);
            chk(frm_err == (bs != 0), "framing R4", frm_err, bs != 0);
            chk(err_sum == ((par_en && bp) || bs != 0) && !ovr_err, "sum R7", err_sum,
                (par_en && bp) || bs != 0);
            do_read();
            chk(!rx_full && !err_sum, "read clears R8", {rx_full, err_sum}, 0);
        end

        len_sel = 2'b01; par_en = 1'b0; two_stop = 1'b0;

        // R6: unread buffer -> overrun, no interrupt, data kept
        send(9'h055, 0, 2'b00, -1, 0);
        ic = irq_count;
        send(9'h0AA, 0, 2'b00, -1, 0);
        chk(ovr_err && err_sum, "overrun R6", ovr_err, 1);
        chk(irq_count == ic && rx_data == 9'h055, "ovr keeps R6", rx_data, 9'h055);
        do_read();

        // R6: read after judgement point still overruns
        two_stop = 1'b1;
        send(9'h011, 0, 2'b00, -1, 0);
        ic = irq_count;
        send(9'h022, 0, 2'b00, 10, 0);
        chk(ovr_err && irq_count == ic, "late read R6", ovr_err, 1);
        do_read();

        // R6: read early in next frame avoids overrun
        send(9'h033, 0, 2'b00, -1, 0);
        send(9'h044, 0, 2'b00, 1, 0);
        chk(!ovr_err && rx_full && rx_data == 9'h044, "early read R6", rx_data, 9'h044);

        // R9: read in the landing cycle, landing wins
        two_stop = 1'b0;
        ic = irq_count;
        send(9'h0E7, 0, 2'b00, 1, 1);
        chk(rx_full && rx_data == 9'h0E7 && irq_count == ic + 1, "collision R9", rx_data, 9'h0E7);
        chk(!ovr_err, "collision no ovr R9", ovr_err, 0);
        do_read();

        // R8: disable clears flags, keeps buffer
        send(9'h03C, 0, 2'b01, -1, 0);
        chk(frm_err, "setup R4", frm_err, 1);
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(!err_sum && rx_full && rx_data == 9'h03C, "disable R8", {err_sum, rx_full}, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule